// File: doc/BRIEF.md
# Synthesizer Divider Reprogramming Sequencer

This block walks a clock synthesizer through a safe change of its divider settings. A one-cycle start pulse brings in new values for the feedback multiplier (M), the reference pre-divider (P), the post-divider shift (S) and the fractional term (K). The block then drives an external register bank over a simple request/acknowledge bus. It reads the output mode field, and it parks the output on the slow reference only when the output was running from the synthesizer. Next it powers the synthesizer down and loads the three control words. It powers the synthesizer back up and polls the lock bit at a fixed interval, up to a bounded number of times. At the end it puts the output back on the synthesizer, but only if the block was the one that moved it off.

Every write is masked. The upper half of the 32-bit write data enables individual bits of the lower half, so bits outside the addressed fields keep their values. The bank base address, the mode register address, the mode field position, the clock frequency and the retry limit are parameters. The wait between polls is derived from the clock frequency so that it spans one microsecond. If the retries run out, a warning flag is raised and the sequence still finishes.

Top module: `clkgen_reseq`

## Requirements
- R1: After an accepted start, the first bus access is a read of the mode register. If the 2-bit mode field at MODE_LSB reads 1 (synthesizer output), the next access writes 0 (slow reference) to that field, with a write mask that covers only those two bits.
- R2: If the mode field reads any value other than 1, the mode register is never written during that sequence.
- R3: The power-down bit (bit 13 of control word 1, at base+4) is set with a masked write before any divider write. It is cleared with a masked write after the last divider write and before the first lock poll.
- R4: The divider writes go in this order. M goes to word 0 (base+0) bits 9:0. P and S go together to word 1 bits 5:0 and 8:6. K goes to word 2 (base+8) bits 15:0. Each write enables only its own fields, so all other bits of those words keep their values.
- R5: The lock bit is bit 15 of the status word at base+0x18. Polling stops at the first read that returns it set.
- R6: There are at most RETRIES status reads. If none of them returns lock, lock_timeout is set and the sequence still runs to completion. A lock seen on the last allowed read does not set lock_timeout.
- R7: Consecutive status reads are separated by at least CLK_HZ/1,000,000 clock cycles.
- R8: A start pulse that arrives while busy is high is ignored. The values it carries are not used, and no extra sequence follows.
- R9: busy is high from the cycle after an accepted start until the end of the sequence. done is high for exactly one cycle at the end, and after it busy is low.
- R10: lock_timeout stays set after the sequence ends and is cleared by the next accepted start.
- R11: A bus request keeps bus_req, bus_we, bus_addr and bus_wdata steady until bus_ack. The next access begins only after that acknowledge.
- R12: The mode field is written back to 1 only when R1 switched it to slow. This write is the last access, after polling ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to reprogram with the values below |
| m_val | input | 10 | Feedback multiplier |
| p_val | input | 6 | Reference pre-divider |
| s_val | input | 3 | Post-divider shift |
| k_val | input | 16 | Fractional term |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| lock_timeout | output | 1 | Lock was not seen within the retry limit |
| bus_req | output | 1 | Bus access request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Upper half is the bit enable mask, lower half is the data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
Two events can fall on the same status read. One is the arrival of the lock bit. The other is running out of retries. The sweep makes the bank model report lock on exactly the last allowed read, and it also runs cases where lock arrives earlier or never arrives. For each case the bench judges the number of status reads in the access log and the final lock_timeout level. In some runs a second start pulse lands while the first sequence is still busy. These runs are judged by the logged accesses, which must carry only the first set of values, and by a count of exactly one done pulse.

// File: rtl/clkgen_reseq_pkg.sv
package clkgen_reseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_MODE, ST_WR_SLOW, ST_PD_ON, ST_WR_M, ST_WR_PS,
    ST_WR_K, ST_PD_OFF, ST_RD_LOCK, ST_WAIT, ST_WR_NORM, ST_DONE
  } seq_state_e;

  // control word field layout (decoded by the register bank)
  localparam int M_W      = 10;
  localparam int P_W      = 6;
  localparam int S_W      = 3;
  localparam int K_W      = 16;
  localparam int S_LSB    = 6;
  localparam int PD_BIT   = 13;
  localparam int LOCK_BIT = 15;

  localparam int OFS_W0   = 0;
  localparam int OFS_W1   = 4;
  localparam int OFS_W2   = 8;
  localparam int OFS_STAT = 24;

  localparam logic [1:0] MODE_SLOW = 2'd0;
  localparam logic [1:0] MODE_NORM = 2'd1;

  function automatic logic [31:0] masked_wr(input logic [15:0] en, input logic [15:0] val);
    return {en, val & en};
  endfunction

endpackage

// File: rtl/reseq_poll.sv
module reseq_poll #(
  parameter int RETRIES  = 1000,
  parameter int POLL_CYC = 50,
  localparam int CNT_W   = $clog2(RETRIES + 1),
  localparam int WAIT_W  = $clog2(POLL_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             poll_ack,
  input  logic             in_wait,
  output logic             wait_done,
  output logic             poll_last,
  output logic [CNT_W-1:0] poll_cnt
);

  logic [WAIT_W-1:0] wait_cnt;
  logic [WAIT_W-1:0] wait_cnt_d;
  logic [CNT_W-1:0]  poll_cnt_d;
  logic              poll_en;

  assign wait_done = in_wait && (wait_cnt == WAIT_W'(POLL_CYC - 1));
  assign poll_last = (poll_cnt == CNT_W'(RETRIES - 1));

  always_comb begin
    wait_cnt_d = in_wait ? wait_cnt + 1'b1 : '0;
    poll_en    = clr || poll_ack;
    poll_cnt_d = clr ? '0 : poll_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      poll_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt_d;
      if (poll_en) poll_cnt <= poll_cnt_d;
    end
  end

  p_wait_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_wait) |-> $past(wait_cnt) == WAIT_W'(POLL_CYC - 1));

  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= CNT_W'(RETRIES));

endmodule

// File: rtl/reseq_busfmt.sv
module reseq_busfmt
  import clkgen_reseq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h80,
  parameter int                MODE_LSB  = 0
) (
  input  seq_state_e        state,
  input  logic [M_W-1:0]    m_q,
  input  logic [P_W-1:0]    p_q,
  input  logic [S_W-1:0]    s_q,
  input  logic [K_W-1:0]    k_q,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       wdata
);

  localparam logic [15:0] MODE_MSK = 16'(3) << MODE_LSB;
  localparam logic [15:0] PD_MSK   = 16'(1) << PD_BIT;
  localparam logic [15:0] M_MSK    = 16'((1 << M_W) - 1);
  localparam logic [15:0] PS_MSK   = 16'((1 << (S_LSB + S_W)) - 1);
  localparam logic [15:0] K_MSK    = 16'hFFFF;

  always_comb begin
    req   = 1'b1;
    we    = 1'b1;
    addr  = '0;
    wdata = '0;
    unique case (state)
      ST_RD_MODE: begin we = 1'b0; addr = MODE_ADDR; end
      ST_WR_SLOW: begin
        addr  = MODE_ADDR;
        wdata = masked_wr(MODE_MSK, 16'(MODE_SLOW) << MODE_LSB);
      end
      ST_PD_ON:   begin addr = BASE_ADDR + ADDR_W'(OFS_W1); wdata = masked_wr(PD_MSK, PD_MSK); end
      ST_WR_M:    begin addr = BASE_ADDR + ADDR_W'(OFS_W0); wdata = masked_wr(M_MSK, 16'(m_q)); end
      ST_WR_PS:   begin
        addr  = BASE_ADDR + ADDR_W'(OFS_W1);
        wdata = masked_wr(PS_MSK, (16'(s_q) << S_LSB) | 16'(p_q));
      end
      ST_WR_K:    begin addr = BASE_ADDR + ADDR_W'(OFS_W2); wdata = masked_wr(K_MSK, k_q); end
      ST_PD_OFF:  begin addr = BASE_ADDR + ADDR_W'(OFS_W1); wdata = masked_wr(PD_MSK, 16'h0000); end
      ST_RD_LOCK: begin we = 1'b0; addr = BASE_ADDR + ADDR_W'(OFS_STAT); end
      ST_WR_NORM: begin
        addr  = MODE_ADDR;
        wdata = masked_wr(MODE_MSK, 16'(MODE_NORM) << MODE_LSB);
      end
      default:    begin req = 1'b0; we = 1'b0; end
    endcase
  end

endmodule

// File: rtl/reseq_ctrl.sv
module reseq_ctrl
  import clkgen_reseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [M_W-1:0] m_in,
  input  logic [P_W-1:0] p_in,
  input  logic [S_W-1:0] s_in,
  input  logic [K_W-1:0] k_in,
  input  logic           bus_ack,
  input  logic           mode_norm,
  input  logic           lock_seen,
  input  logic           wait_done,
  input  logic           poll_last,
  output seq_state_e     state,
  output logic           switched,
  output logic [M_W-1:0] m_q,
  output logic [P_W-1:0] p_q,
  output logic [S_W-1:0] s_q,
  output logic [K_W-1:0] k_q,
  output logic           lock_timeout
);

  seq_state_e state_d;
  logic       accept;
  logic       sw_en;
  logic       sw_d;
  logic       to_set;
  logic       poll_end;

  assign accept   = (state == ST_IDLE) && start;
  assign poll_end = (state == ST_RD_LOCK) && bus_ack;
  assign sw_en    = accept || ((state == ST_RD_MODE) && bus_ack);
  assign sw_d     = (state == ST_RD_MODE) && mode_norm;
  assign to_set   = poll_end && !lock_seen && poll_last;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:    if (start)   state_d = ST_RD_MODE;
      ST_RD_MODE: if (bus_ack) state_d = mode_norm ? ST_WR_SLOW : ST_PD_ON;
      ST_WR_SLOW: if (bus_ack) state_d = ST_PD_ON;
      ST_PD_ON:   if (bus_ack) state_d = ST_WR_M;
      ST_WR_M:    if (bus_ack) state_d = ST_WR_PS;
      ST_WR_PS:   if (bus_ack) state_d = ST_WR_K;
      ST_WR_K:    if (bus_ack) state_d = ST_PD_OFF;
      ST_PD_OFF:  if (bus_ack) state_d = ST_RD_LOCK;
      ST_RD_LOCK: if (bus_ack) begin
        if (lock_seen || poll_last) state_d = switched ? ST_WR_NORM : ST_DONE;
        else                        state_d = ST_WAIT;
      end
      ST_WAIT:    if (wait_done) state_d = ST_RD_LOCK;
      ST_WR_NORM: if (bus_ack)   state_d = ST_DONE;
      ST_DONE:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      switched     <= 1'b0;
      lock_timeout <= 1'b0;
    end else begin
      state <= state_d;
      if (sw_en) switched <= sw_d;
      if (accept)      lock_timeout <= 1'b0;
      else if (to_set) lock_timeout <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      p_q <= '0;
      s_q <= '0;
      k_q <= '0;
    end else if (accept) begin
      m_q <= m_in;
      p_q <= p_in;
      s_q <= s_in;
      k_q <= k_in;
    end
  end

  p_restore_needs_switch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_NORM) |-> switched);

  p_values_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(m_q) && $stable(p_q) && $stable(s_q) && $stable(k_q));

endmodule

// File: rtl/clkgen_reseq.sv
module clkgen_reseq
  import clkgen_reseq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h80,
  parameter int                MODE_LSB  = 0,
  parameter int                CLK_HZ    = 50_000_000,
  parameter int                RETRIES   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [M_W-1:0]    m_val,
  input  logic [P_W-1:0]    p_val,
  input  logic [S_W-1:0]    s_val,
  input  logic [K_W-1:0]    k_val,
  output logic              busy,
  output logic              done,
  output logic              lock_timeout,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);

  localparam int POLL_RAW = CLK_HZ / 1_000_000;
  localparam int POLL_CYC = (POLL_RAW < 1) ? 1 : POLL_RAW;
  localparam int CNT_W    = $clog2(RETRIES + 1);

  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  seq_state_e       state;
  logic             switched;
  logic [M_W-1:0]   m_q;
  logic [P_W-1:0]   p_q;
  logic [S_W-1:0]   s_q;
  logic [K_W-1:0]   k_q;
  logic             mode_norm;
  logic             lock_seen;
  logic             wait_done;
  logic             poll_last;
  logic [CNT_W-1:0] poll_cnt;
  logic             rdata_unused;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign mode_norm    = (bus_rdata[MODE_LSB +: 2] == MODE_NORM);
  assign lock_seen    = bus_rdata[LOCK_BIT];
  assign rdata_unused = ^bus_rdata;
  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_DONE);

  reseq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .start        (start),
    .m_in         (m_val),
    .p_in         (p_val),
    .s_in         (s_val),
    .k_in         (k_val),
    .bus_ack      (bus_ack),
    .mode_norm    (mode_norm),
    .lock_seen    (lock_seen),
    .wait_done    (wait_done),
    .poll_last    (poll_last),
    .state        (state),
    .switched     (switched),
    .m_q          (m_q),
    .p_q          (p_q),
    .s_q          (s_q),
    .k_q          (k_q),
    .lock_timeout (lock_timeout)
  );

  reseq_poll #(.RETRIES(RETRIES), .POLL_CYC(POLL_CYC)) u_poll (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr       (state == ST_IDLE),
    .poll_ack  ((state == ST_RD_LOCK) && bus_ack),
    .in_wait   (state == ST_WAIT),
    .wait_done (wait_done),
    .poll_last (poll_last),
    .poll_cnt  (poll_cnt)
  );

  reseq_busfmt #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MODE_ADDR(MODE_ADDR), .MODE_LSB(MODE_LSB)
  ) u_busfmt (
    .state (state),
    .m_q   (m_q),
    .p_q   (p_q),
    .s_q   (s_q),
    .k_q   (k_q),
    .req   (bus_req),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata)
  );

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done && !busy);

  p_timeout_full_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(lock_timeout) |-> poll_cnt == CNT_W'(RETRIES));

endmodule

// File: tb/clkgen_reseq_tb.sv
module clkgen_reseq_tb;
  import clkgen_reseq_pkg::*;

  localparam int          CLK_HZ   = 4_000_000;
  localparam int          POLL_CYC = CLK_HZ / 1_000_000;
  localparam int          RETRIES  = 8;
  localparam int          MLSB     = 4;
  localparam logic [7:0]  BASE     = 8'h40;
  localparam logic [7:0]  MADDR    = 8'h80;
  localparam logic [15:0] FMSK     = 16'h3 << MLSB;

  logic clk, rst_n, start;
  logic [M_W-1:0] m_val;
  logic [P_W-1:0] p_val;
  logic [S_W-1:0] s_val;
  logic [K_W-1:0] k_val;
  logic busy, done, lock_timeout, bus_req, bus_we, bus_ack;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  clkgen_reseq #(
    .ADDR_W(8), .BASE_ADDR(BASE), .MODE_ADDR(MADDR), .MODE_LSB(MLSB),
    .CLK_HZ(CLK_HZ), .RETRIES(RETRIES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .m_val(m_val), .p_val(p_val),
    .s_val(s_val), .k_val(k_val), .busy(busy), .done(done),
    .lock_timeout(lock_timeout), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // bank model configuration, driven by the stimulus process only
  logic        load;
  logic [15:0] cfg_mode, cfg_w0, cfg_w1, cfg_w2;
  int          cfg_lat, cfg_lock;

  // bank model state, driven by the model process only
  logic [15:0] r_mode, r_w0, r_w1, r_w2;
  logic        pd_clr, pend, p_we;
  logic [7:0]  p_a;
  logic [31:0] p_d;
  int cnt, cyc, last_rd, min_gap, stat_reads, nlog, done_pulses, hold_err;
  logic        lg_we [0:31];
  logic [7:0]  lg_a  [0:31];
  logic [31:0] lg_d  [0:31];

  function automatic logic [15:0] apply(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load) begin
      r_mode <= cfg_mode; r_w0 <= cfg_w0; r_w1 <= cfg_w1; r_w2 <= cfg_w2;
      pd_clr <= 1'b0; nlog <= 0; stat_reads <= 0; min_gap <= 1000000;
      last_rd <= -1; cnt <= 0; bus_ack <= 1'b0; bus_rdata <= '0;
      done_pulses <= 0; hold_err <= 0; pend <= 1'b0;
    end else begin
      bus_ack <= 1'b0;
      if (done) done_pulses <= done_pulses + 1;
      if (pend && (!bus_req || bus_addr != p_a || bus_wdata != p_d || bus_we != p_we))
        hold_err <= hold_err + 1;
      pend <= bus_req && !bus_ack;
      p_a <= bus_addr; p_d <= bus_wdata; p_we <= bus_we;
      if (bus_req && !bus_ack) begin
        if (cnt >= cfg_lat - 1) begin
          cnt <= 0;
          bus_ack <= 1'b1;
          if (nlog < 32) begin
            lg_we[nlog] <= bus_we; lg_a[nlog] <= bus_addr; lg_d[nlog] <= bus_wdata;
            nlog <= nlog + 1;
          end
          if (bus_we) begin
            bus_rdata <= '0;
            if (bus_addr == MADDR) r_mode <= apply(r_mode, bus_wdata);
            else if (bus_addr == BASE) r_w0 <= apply(r_w0, bus_wdata);
            else if (bus_addr == BASE + 8'd4) begin
              r_w1 <= apply(r_w1, bus_wdata);
              if (bus_wdata[16 + PD_BIT] && !bus_wdata[PD_BIT]) pd_clr <= 1'b1;
            end else if (bus_addr == BASE + 8'd8) r_w2 <= apply(r_w2, bus_wdata);
          end else begin
            if (bus_addr == MADDR) bus_rdata <= {16'h0, r_mode};
            else if (bus_addr == BASE + 8'd24) begin
              stat_reads <= stat_reads + 1;
              if (last_rd >= 0 && cyc - last_rd < min_gap) min_gap <= cyc - last_rd;
              last_rd <= cyc;
              bus_rdata <= (pd_clr && cfg_lock != 0 && stat_reads + 1 >= cfg_lock)
                           ? 32'h0000_8000 : 32'h0;
            end else bus_rdata <= 32'hDEAD_0000;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic        e_we [0:31];
  logic [7:0]  e_a  [0:31];
  logic [31:0] e_d  [0:31];
  int          ne;
  logic        prev_warn;

  task automatic push(input logic we, input logic [7:0] a, input logic [31:0] d);
    e_we[ne] = we; e_a[ne] = a; e_d[ne] = d; ne++;
  endtask

  task automatic run(input logic [1:0] minit, input int lock_after, input int lat,
                     input int idx, input bit intrude);
    logic [M_W-1:0] m; logic [P_W-1:0] p; logic [S_W-1:0] s; logic [K_W-1:0] k;
    int n, nstat;
    bit warn_exp, norm;
    m = M_W'(idx * 37 + 5); p = P_W'(idx * 11 + 1); s = S_W'(idx);
    k = K_W'(idx * 4099 + 7);
    norm = (minit == 2'd1);
    @(negedge clk);
    cfg_mode = (16'hA5C3 & ~FMSK) | (16'(minit) << MLSB);
    cfg_w0 = 16'hFC00 ^ 16'(idx); cfg_w1 = 16'hD200 | 16'(idx); cfg_w2 = 16'h1234;
    cfg_lat = lat; cfg_lock = lock_after;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(lock_timeout == prev_warn, "R10", "flag held until next start", lock_timeout, prev_warn);
    start = 1'b1; m_val = m; p_val = p; s_val = s; k_val = k;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    chk(lock_timeout == 1'b0, "R10", "flag cleared by start", lock_timeout, 0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      start = 1'b1; m_val = ~m; p_val = ~p; s_val = ~s; k_val = ~k;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, "R9", "sequence finished before watchdog", n, 0);
    @(negedge clk);
    chk(!done && !busy, "R9", "done one cycle then idle", {done, busy}, 0);
    nstat = (lock_after >= 1 && lock_after <= RETRIES) ? lock_after : RETRIES;
    warn_exp = !(lock_after >= 1 && lock_after <= RETRIES);
    chk(lock_timeout == warn_exp, "R6", "lock_timeout level", lock_timeout, warn_exp);
    prev_warn = warn_exp;
    ne = 0;
    push(1'b0, MADDR, 32'h0);
    if (norm) push(1'b1, MADDR, {FMSK, 16'h0});
    push(1'b1, BASE + 8'd4, {16'h2000, 16'h2000});
    push(1'b1, BASE,        {16'h03FF, 16'(m)});
    push(1'b1, BASE + 8'd4, {16'h01FF, (16'(s) << 6) | 16'(p)});
    push(1'b1, BASE + 8'd8, {16'hFFFF, k});
    push(1'b1, BASE + 8'd4, {16'h2000, 16'h0000});
    for (int i = 0; i < nstat; i++) push(1'b0, BASE + 8'd24, 32'h0);
    if (norm) push(1'b1, MADDR, {FMSK, 16'h1 << MLSB});
    chk(nlog == ne, "R5", "number of bus accesses", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) begin
      string rq;
      rq = (e_a[i] == MADDR) ? (i == 0 ? "R1" : (norm ? "R12" : "R2"))
         : (e_a[i] == BASE + 8'd24) ? "R5" : (i <= 2 || i >= ne - 2) ? "R3" : "R4";
      chk(lg_we[i] == e_we[i] && lg_a[i] == e_a[i] && (!e_we[i] || lg_d[i] == e_d[i]),
          rq, $sformatf("access %0d", i), {lg_we[i], lg_a[i], lg_d[i]}, {e_we[i], e_a[i], e_d[i]});
    end
    chk(stat_reads == nstat, "R6", "status read count", stat_reads, nstat);
    chk(r_mode == cfg_mode, "R2", "final mode register", r_mode, cfg_mode);
    chk(r_w0 == ((cfg_w0 & 16'hFC00) | 16'(m)), "R4", "word0", r_w0, (cfg_w0 & 16'hFC00) | 16'(m));
    chk(r_w1 == ((cfg_w1 & 16'hDE00) | (16'(s) << 6) | 16'(p)), "R3", "word1 with power-down clear",
        r_w1, (cfg_w1 & 16'hDE00) | (16'(s) << 6) | 16'(p));
    chk(r_w2 == k, "R4", "word2", r_w2, k);
    if (nstat > 1) chk(min_gap >= POLL_CYC, "R7", "poll spacing", min_gap, POLL_CYC);
    chk(hold_err == 0, "R11", "request held until ack", hold_err, 0);
    chk(done_pulses == 1, "R8", "single sequence per accepted start", done_pulses, 1);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lock_set [4];
    logic [1:0] mode_set [3];
    int idx;
    lock_set = '{1, 3, RETRIES, 0};
    mode_set = '{2'd1, 2'd0, 2'd2};
    rst_n = 1'b0; start = 1'b0; load = 1'b1; prev_warn = 1'b0;
    m_val = '0; p_val = '0; s_val = '0; k_val = '0;
    cfg_mode = '0; cfg_w0 = '0; cfg_w1 = '0; cfg_w2 = '0; cfg_lat = 1; cfg_lock = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !lock_timeout && !bus_req, "R9", "reset state",
        {busy, done, lock_timeout, bus_req}, 0);
    rst_n = 1'b1;
    load = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !bus_req, "R11", "idle bus after reset", {busy, bus_req}, 0);
    idx = 0;
    for (int mi = 0; mi < 3; mi++)
      for (int li = 0; li < 4; li++)
        for (int lt = 1; lt <= 3; lt += 2) begin
          run(mode_set[mi], lock_set[li], lt, idx, (idx % 5) == 2);
          idx++;
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule